// File: doc/BRIEF.md
# Early-Start Trigger for Pipelined Row Cores

This block lets a chain of pipelined row-processing cores hand work from one to the next without a completion handshake. When a step is issued, the block records the opcode of the step now running and the opcode of the step that comes after it. It then counts clock cycles from that issue. A constant offset table, addressed by the pair of opcodes, gives two launch points. When the count reaches the first, the block pulses a trigger that starts the next elimination pass early. When the count reaches the second, it pulses a trigger that readies the write port of the core that will receive the eliminated row.

The table holds 8 by 8 entries and is built at elaboration time from three per-opcode parameter arrays. These are the latency of each opcode when it runs as the current step (`LAT_TBL`), how far each opcode can start ahead when it is the following step (`LEAD_TBL`), and the delay from the elimination launch to row arrival for each current opcode (`LAG_TBL`). The counter saturates once both triggers have fired. A fresh issue always restarts the count from zero and discards any trigger that is still pending.

Top module: `est_trigger`

## Requirements
- R1: While reset is asserted, and after reset until the first issue, both `elim_go_o` and `wb_prep_o` stay low.
- R2: For a step issued at clock edge E (with `issue_i` high in the cycle before E), `elim_go_o` is high in exactly one cycle: the cycle that begins at edge E+D, where D is the elimination offset. An offset of 0 therefore fires in the cycle right after the issue edge.
- R3: The opcode inputs are 3-bit indices into the parameter arrays. The elimination offset is D = `LAT_TBL[cur] - LEAD_TBL[nxt]` when that difference is positive, and 0 otherwise.
- R4: `wb_prep_o` fires exactly once per step, at offset D + `LAG_TBL[cur]`. It never fires before `elim_go_o` of the same step.
- R5: Each trigger is a pulse one cycle wide.
- R6: After both triggers of a step have fired, the counter holds its value and never wraps. Neither trigger fires again until the next issue.
- R7: An issue that arrives while a trigger is still pending cancels that trigger. The count restarts from zero, and timing follows the new opcode pair.
- R8: In any cycle where `issue_i` is high, both outputs are low, even if a trigger of the previous step would have matched in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| issue_i | input | 1 | Step issue strobe, one cycle |
| cur_op_i | input | 3 | Opcode of the step being issued |
| nxt_op_i | input | 3 | Opcode of the step that follows |
| elim_go_o | output | 1 | Early elimination launch pulse |
| wb_prep_o | output | 1 | Write-back preparation pulse for the receiving core |

## Verification
On every cycle, the assertions check the following: each trigger lasts one cycle, a zero elimination offset fires right after the issue edge, write-back preparation never runs ahead of elimination, the counter restarts on an issue, and the counter holds without wrapping once it is idle or at its ceiling. The exact launch cycle for each opcode pair, including the floor at zero when the lead exceeds the latency, can only be shown by the bench scenarios, which compare pulse positions against a reference model of the offset formula. The same holds for cancellation by an early re-issue, suppression in the cycle where an issue collides with a due trigger, and the absence of a second pulse over a window longer than the counter range.

// File: rtl/est_pkg.sv
package est_pkg;

  // Elimination gap: current latency minus the lead of the following
  // opcode, floored at zero.
  function automatic int unsigned elim_gap(input int unsigned lat,
                                           input int unsigned lead);
    return (lat > lead) ? (lat - lead) : 0;
  endfunction

  localparam int NUM_TRIG = 2;
  localparam int TRIG_EL  = 0;
  localparam int TRIG_WB  = 1;

endpackage

// File: rtl/est_offset_rom.sv
module est_offset_rom #(
  parameter int          OPC_W = 3,
  parameter int          CNT_W = 6,
  parameter int unsigned LAT_TBL  [2**OPC_W] = '{4, 6, 9, 12, 3, 0, 15, 20},
  parameter int unsigned LEAD_TBL [2**OPC_W] = '{0, 2, 3, 5, 1, 8, 4, 2},
  parameter int unsigned LAG_TBL  [2**OPC_W] = '{2, 3, 1, 4, 0, 5, 2, 6}
) (
  input  logic [OPC_W-1:0] cur_i,
  input  logic [OPC_W-1:0] nxt_i,
  output logic [CNT_W-1:0] el_off_o,
  output logic [CNT_W-1:0] wb_off_o
);

  localparam int NOPC = 2**OPC_W;
  localparam int NENT = NOPC * NOPC;

  logic [CNT_W-1:0] el_rom [NENT];
  logic [CNT_W-1:0] wb_rom [NENT];

  for (genvar c = 0; c < NOPC; c++) begin : g_cur
    for (genvar n = 0; n < NOPC; n++) begin : g_nxt
      localparam int unsigned EL = est_pkg::elim_gap(LAT_TBL[c], LEAD_TBL[n]);
      localparam int unsigned WB = EL + LAG_TBL[c];
      assign el_rom[c*NOPC+n] = CNT_W'(EL);
      assign wb_rom[c*NOPC+n] = CNT_W'(WB);
    end
  end

  always_comb begin
    el_off_o = el_rom[{cur_i, nxt_i}];
    wb_off_o = wb_rom[{cur_i, nxt_i}];
  end

endmodule

// File: rtl/est_cycle_counter.sv
module est_cycle_counter #(
  parameter int CNT_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             restart_i,
  input  logic             run_i,
  output logic [CNT_W-1:0] cnt_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = restart_i || (run_i && (cnt_q != CNT_MAX));
    cnt_d  = restart_i ? '0 : (cnt_q + 1'b1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign cnt_o = cnt_q;

  AST_CNT_RESTART: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_i |=> (cnt_q == '0)); // R7
  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cnt_q == CNT_MAX) && !restart_i) |=> (cnt_q == CNT_MAX)); // R6
  AST_CNT_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !restart_i) |=> $stable(cnt_q)); // R6

endmodule

// File: rtl/est_hit.sv
module est_hit #(
  parameter int CNT_W = 6
) (
  input  logic             armed_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [CNT_W-1:0] off_i,
  output logic             hit_o
);

  always_comb hit_o = armed_i && (cnt_i == off_i);

endmodule

// File: rtl/est_trigger.sv
module est_trigger #(
  parameter int          OPC_W = 3,
  parameter int          CNT_W = 6,
  parameter int unsigned LAT_TBL  [2**OPC_W] = '{4, 6, 9, 12, 3, 0, 15, 20},
  parameter int unsigned LEAD_TBL [2**OPC_W] = '{0, 2, 3, 5, 1, 8, 4, 2},
  parameter int unsigned LAG_TBL  [2**OPC_W] = '{2, 3, 1, 4, 0, 5, 2, 6}
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             issue_i,
  input  logic [OPC_W-1:0] cur_op_i,
  input  logic [OPC_W-1:0] nxt_op_i,
  output logic             elim_go_o,
  output logic             wb_prep_o
);

  import est_pkg::*;

  logic [CNT_W-1:0]    rom_off [NUM_TRIG];
  logic [CNT_W-1:0]    off_q   [NUM_TRIG];
  logic [NUM_TRIG-1:0] armed_q, armed_d;
  logic [NUM_TRIG-1:0] hit;
  logic [CNT_W-1:0]    cnt;

  est_offset_rom #(
    .OPC_W(OPC_W), .CNT_W(CNT_W),
    .LAT_TBL(LAT_TBL), .LEAD_TBL(LEAD_TBL), .LAG_TBL(LAG_TBL)
  ) u_rom (
    .cur_i    (cur_op_i),
    .nxt_i    (nxt_op_i),
    .el_off_o (rom_off[TRIG_EL]),
    .wb_off_o (rom_off[TRIG_WB])
  );

  est_cycle_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .restart_i (issue_i),
    .run_i     (|armed_q),
    .cnt_o     (cnt)
  );

  for (genvar t = 0; t < NUM_TRIG; t++) begin : g_trig
    est_hit #(.CNT_W(CNT_W)) u_hit (
      .armed_i (armed_q[t]),
      .cnt_i   (cnt),
      .off_i   (off_q[t]),
      .hit_o   (hit[t])
    );

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      off_q[t] <= '0;
      else if (issue_i) off_q[t] <= rom_off[t];
    end
  end

  always_comb begin
    armed_d = issue_i ? {NUM_TRIG{1'b1}} : (armed_q & ~hit);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) armed_q <= '0;
    else         armed_q <= armed_d;
  end

  always_comb begin
    elim_go_o = hit[TRIG_EL] && !issue_i;
    wb_prep_o = hit[TRIG_WB] && !issue_i;
  end

  AST_ELIM_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    elim_go_o |=> !elim_go_o); // R5
  AST_WB_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_prep_o |=> !wb_prep_o); // R5
  AST_ZERO_OFFSET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (issue_i && (rom_off[TRIG_EL] == '0)) |=> (elim_go_o || issue_i)); // R2
  AST_WB_AFTER_ELIM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_prep_o |-> (elim_go_o || !armed_q[TRIG_EL])); // R4

endmodule

// File: tb/tb_est_trigger.sv
`timescale 1ns/1ps
module tb_est_trigger;

  localparam int unsigned T_LAT  [8] = '{4, 6, 9, 12, 3, 0, 15, 20};
  localparam int unsigned T_LEAD [8] = '{0, 2, 3, 5, 1, 8, 4, 2};
  localparam int unsigned T_LAG  [8] = '{2, 3, 1, 4, 0, 5, 2, 6};

  logic       clk = 1'b0;
  logic       rst_n;
  logic       issue;
  logic [2:0] cur_op, nxt_op;
  logic       elim_go, wb_prep;

  int n_vec  = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  est_trigger #(
    .OPC_W(3), .CNT_W(6),
    .LAT_TBL(T_LAT), .LEAD_TBL(T_LEAD), .LAG_TBL(T_LAG)
  ) dut (
    .clk_i(clk), .rst_ni(rst_n), .issue_i(issue),
    .cur_op_i(cur_op), .nxt_op_i(nxt_op),
    .elim_go_o(elim_go), .wb_prep_o(wb_prep)
  );

  function automatic int model_el(input int c, input int n);
    return (T_LAT[c] > T_LEAD[n]) ? int'(T_LAT[c] - T_LEAD[n]) : 0;
  endfunction

  function automatic int model_wb(input int c, input int n);
    return model_el(c, n) + int'(T_LAG[c]);
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Issue a step; returns at the falling edge of cycle 0 after the issue edge.
  task automatic launch(input int c, input int n);
    @(negedge clk);
    cur_op = 3'(c); nxt_op = 3'(n); issue = 1'b1;
    @(negedge clk);
    issue = 1'b0;
  endtask

  task automatic watch(input int cycles, output int el_at, output int wb_at,
                       output int el_cnt, output int wb_cnt);
    el_at = -1; wb_at = -1; el_cnt = 0; wb_cnt = 0;
    for (int t = 0; t < cycles; t++) begin
      #1;
      if (elim_go) begin el_cnt++; el_at = t; end
      if (wb_prep) begin wb_cnt++; wb_at = t; end
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int ea, wa, ec, wc;
    rst_n = 1'b0; issue = 1'b0; cur_op = '0; nxt_op = '0;
    repeat (3) @(negedge clk);
    check(!elim_go && !wb_prep, "R1 outputs in reset", int'({elim_go, wb_prep}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    watch(40, ea, wa, ec, wc);
    check(ec == 0, "R1 no elim pulse before issue", ec, 0);
    check(wc == 0, "R1 no wb pulse before issue", wc, 0);
  endtask

  // R2 R3 R4 R5 R6: one step, observed over a window beyond the counter range
  task automatic t_step(input int c, input int n, input int win);
    int ea, wa, ec, wc;
    launch(c, n);
    watch(win, ea, wa, ec, wc);
    check(ec == 1, "R5 single elim pulse", ec, 1);
    check(ea == model_el(c, n), "R2 R3 elim cycle", ea, model_el(c, n));
    check(wc == 1, "R4 single wb pulse", wc, 1);
    check(wa == model_wb(c, n), "R4 wb cycle", wa, model_wb(c, n));
  endtask

  // R7: re-issue before pending triggers fire
  task automatic t_cancel();
    int ea, wa, ec, wc;
    launch(7, 0);               // offsets 20 and 26
    watch(5, ea, wa, ec, wc);
    check(ec == 0 && wc == 0, "R7 nothing before re-issue", ec + wc, 0);
    launch(1, 1);               // offsets 4 and 7
    watch(90, ea, wa, ec, wc);
    check(ec == 1 && ea == model_el(1, 1), "R7 restart elim cycle", ea, model_el(1, 1));
    check(wc == 1 && wa == model_wb(1, 1), "R7 restart wb cycle", wa, model_wb(1, 1));
  endtask

  // R8: issue coinciding with a due trigger mutes it
  task automatic t_collide();
    int ea, wa, ec, wc;
    launch(0, 0);               // offsets 4 and 6
    watch(4, ea, wa, ec, wc);
    check(ec == 0, "R8 no early elim", ec, 0);
    cur_op = 3'd2; nxt_op = 3'd7; issue = 1'b1;   // cycle 4: old elim was due
    #1;
    check(!elim_go && !wb_prep, "R8 muted on issue", int'({elim_go, wb_prep}), 0);
    @(negedge clk);
    issue = 1'b0;
    watch(90, ea, wa, ec, wc);
    check(ec == 1 && ea == model_el(2, 7), "R8 new elim cycle", ea, model_el(2, 7));
    check(wc == 1 && wa == model_wb(2, 7), "R8 new wb cycle", wa, model_wb(2, 7));
  endtask

  initial begin
    #1000000;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

  initial begin
    t_reset();
    t_step(0, 0, 40);
    t_step(3, 1, 40);
    t_step(4, 5, 40);           // R3 floor at zero
    t_step(5, 2, 40);           // R2 zero latency
    t_step(6, 3, 40);
    t_step(2, 7, 40);
    t_step(7, 0, 150);          // R6 long window, no wrap re-fire
    t_cancel();
    t_collide();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule